// File: doc/BRIEF.md
# Full-Speed Serial Receive Path

This block turns a stream of line samples into bytes. Each sample is one differential pair reading, already aligned to the bit grid and marked by a one-clock strobe. The receiver decodes the pair into J, K or SE0 and hunts for the start-of-packet marker. After that it undoes the NRZI coding, drops stuffed bits and assembles data least significant bit first. It hands each finished byte to the consuming logic through a registered hold stage together with activity, valid and error flags.

A packet ends in one of three ways. It closes cleanly on an end-of-packet marker at a byte boundary. It stops early on a stuffing or line-coding violation, which is reported and then dropped. If the end marker arrives in the middle of a byte, the error is reported and the packet stays open until the line returns to idle. Between strobes the pair inputs are never looked at.

Top module: `usb_rx_path`

## Requirements
- R1: While `rst_ni` is low, `rx_active_o`, `rx_valid_o` and `rx_error_o` are 0 and `data_o` is 8'h00. The receiver starts hunting on the second clock edge after reset is released.
- R2: Line states are J = (dp=1, dm=0), K = (dp=0, dm=1) and SE0 = (0, 0). The level of a non-SE0 sample is taken from `dp_i`. While hunting, the eight most recent strobed non-SE0 levels K J K J K J K K mark the end of the start marker, and `rx_active_o` rises on the clock after the strobe that carried the final K. A strobed SE0 while hunting restarts the search.
- R3: A start marker longer than eight bits, up to 32 bits (extra leading K J pairs), is accepted in the same way.
- R4: After the marker, each strobed level equal to the previous one decodes as 1 and a change decodes as 0. The first data bit is compared with the final K of the marker. Bits fill the byte least significant bit first.
- R5: A 0 that follows six consecutive decoded 1s is dropped and does not count toward the byte. The trailing 1 of the start marker counts as the first of the six.
- R6: When the eighth data bit arrives, that byte appears on `data_o` and `rx_valid_o` is high for exactly the next clock. `data_o` then holds until the next byte. `rx_valid_o` is low in every other clock.
- R7: Two or more strobed SE0 samples followed by a strobed J, arriving at a byte boundary, end the packet. `rx_active_o` falls on the clock after the J strobe, with no error.
- R8: A seventh consecutive decoded 1 is a stuffing error. `rx_error_o` is high for one clock, starting the clock after that strobe, and `rx_active_o` stays high during it. On the following clock `rx_active_o` and `rx_error_o` are both low and the receiver hunts again.
- R9: An SE0 run that is not the end marker is a receive error handled as in R8. Such a run is a single SE0 followed by J or K, or two or more SE0 followed by K.
- R10: An end marker that arrives with one to seven bits of a byte assembled raises `rx_error_o` for one clock. `rx_active_o` then stays high until a strobed J, and falls on the clock after that strobe.
- R11: A packet that starts right after a previous one has ended, whether it closed cleanly or aborted, is decoded correctly. The decoder's reference level is reset to J while hunting.
- R12: `dp_i` and `dm_i` have no effect in clocks where `bit_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-time strobe; pair sampled when high |
| dp_i | input | 1 | Positive line of the pair |
| dm_i | input | 1 | Negative line of the pair |
| data_o | output | 8 | Last received byte |
| rx_active_o | output | 1 | Packet in progress |
| rx_valid_o | output | 1 | New byte on data_o this clock |
| rx_error_o | output | 1 | Receive error pulse |

## Verification
Packets are sent with mixed-bit bytes, runs of 8'hFF that force stuffed bits, and 32-bit start markers. Together these separate correct NRZI decoding, bit ordering and stuff removal from the byte-valid timing, including byte times that carry no new byte. Unstuffed runs of 1s, a stray single SE0, and an end marker in the middle of a byte drive the two abort routes apart: one drops activity at once, the other holds it until idle. Random pair values between strobes, an SE0 during the hunt, and back-to-back packets show that only strobed samples count and that the search restarts cleanly.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [3:0] {
    ST_RESET,
    ST_HUNT,
    ST_SYNC,
    ST_DATA,
    ST_GAP,
    ST_EOP,
    ST_ERR,
    ST_ABORT1,
    ST_ABORT2,
    ST_TERM
  } rx_state_e;

  localparam logic LVL_J = 1'b1;
  localparam logic LVL_K = 1'b0;
endpackage

// File: rtl/usb_rx_line.sv
module usb_rx_line
  import usb_rx_pkg::*;
#(
  parameter int               SYNC_W   = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'b0101_0100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic dp_i,
  input  logic dm_i,
  input  logic hunt_i,
  output logic lvl_o,
  output logic se0_o,
  output logic sync_hit_o
);
  logic [SYNC_W-1:0] hist_q;
  logic [SYNC_W-1:0] window;

  assign lvl_o  = dp_i;
  assign se0_o  = ~dp_i & ~dm_i;
  assign window = {hist_q[SYNC_W-2:0], lvl_o};
  assign sync_hit_o = hunt_i & bit_en_i & ~se0_o & (window == SYNC_PAT);

  // history reads all-J on every entry to the hunt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= {SYNC_W{LVL_J}};
    end else if (!hunt_i) begin
      hist_q <= {SYNC_W{LVL_J}};
    end else if (bit_en_i) begin
      hist_q <= se0_o ? {SYNC_W{LVL_J}} : window;
    end
  end
endmodule

// File: rtl/usb_rx_destuff.sv
module usb_rx_destuff
  import usb_rx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int RUN_LEN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hunt_i,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              lvl_i,
  output logic              byte_done_o,
  output logic              stuff_err_o,
  output logic              partial_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int CNT_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int ONES_W = $clog2(RUN_LEN + 1);

  logic              prev_q;
  logic [ONES_W-1:0] ones_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] hold_q;

  logic              bit_d;
  logic              at_run;
  logic              take;
  logic [BYTE_W-1:0] next_byte;

  assign bit_d       = (lvl_i == prev_q);
  assign at_run      = (ones_q == ONES_W'(RUN_LEN));
  assign take        = step_i & ~at_run;
  assign stuff_err_o = step_i & at_run & bit_d;
  assign byte_done_o = take & (cnt_q == CNT_W'(BYTE_W - 1));
  assign next_byte   = {bit_d, sh_q[BYTE_W-1:1]};
  assign partial_o   = (cnt_q != '0);
  assign data_o      = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= LVL_J;
      ones_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
    end else if (hunt_i) begin
      // marker ends on K with a decoded 1 already counted
      prev_q <= start_i ? lvl_i : LVL_J;
      ones_q <= ONES_W'(1);
      cnt_q  <= '0;
    end else if (step_i) begin
      prev_q <= lvl_i;
      if (at_run) begin
        ones_q <= '0;
      end else begin
        ones_q <= bit_d ? ones_q + 1'b1 : '0;
        sh_q   <= next_byte;
        cnt_q  <= byte_done_o ? '0 : cnt_q + 1'b1;
      end
      if (byte_done_o) hold_q <= next_byte;
    end
  end
endmodule

// File: rtl/usb_rx_fsm.sv
module usb_rx_fsm
  import usb_rx_pkg::*;
#(
  parameter int EOP_SE0 = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_en_i,
  input  logic      se0_i,
  input  logic      lvl_i,
  input  logic      sync_hit_i,
  input  logic      byte_done_i,
  input  logic      stuff_err_i,
  input  logic      partial_i,
  output rx_state_e state_o,
  output logic      hunt_o,
  output logic      step_o
);
  localparam int SW = $clog2(EOP_SE0 + 1);

  rx_state_e st_q, st_d;
  logic [SW-1:0] se0_q, se0_d;
  logic ab2_q, ab2_d;
  logic rcv;

  assign rcv     = st_q inside {ST_SYNC, ST_DATA, ST_GAP};
  assign hunt_o  = (st_q == ST_HUNT);
  assign step_o  = rcv & bit_en_i & ~se0_i & (se0_q == '0);
  assign state_o = st_q;

  always_comb begin
    st_d  = st_q;
    se0_d = rcv ? se0_q : '0;
    ab2_d = ab2_q;
    unique case (st_q)
      ST_RESET: st_d = ST_HUNT;
      ST_HUNT:  if (sync_hit_i) st_d = ST_SYNC;
      ST_SYNC, ST_DATA, ST_GAP: begin
        if (st_q == ST_DATA) st_d = ST_GAP;
        if (bit_en_i) begin
          if (se0_i) begin
            if (se0_q != SW'(EOP_SE0)) se0_d = se0_q + 1'b1;
          end else if (se0_q == SW'(EOP_SE0) && lvl_i == LVL_J) begin
            if (partial_i) begin
              st_d  = ST_ERR;
              ab2_d = 1'b1;
            end else begin
              st_d = ST_EOP;
            end
          end else if (se0_q != '0 || stuff_err_i) begin
            st_d  = ST_ERR;
            ab2_d = 1'b0;
          end else if (byte_done_i) begin
            st_d = ST_DATA;
          end
        end
      end
      ST_EOP, ST_ABORT1, ST_TERM: st_d = ST_HUNT;
      ST_ERR:    st_d = ab2_q ? ST_ABORT2 : ST_ABORT1;
      ST_ABORT2: if (bit_en_i && !se0_i && lvl_i == LVL_J) st_d = ST_TERM;
      default:   st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RESET;
      se0_q <= '0;
      ab2_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      se0_q <= se0_d;
      ab2_q <= ab2_d;
    end
  end
endmodule

// File: rtl/usb_rx_path.sv
module usb_rx_path
  import usb_rx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int RUN_LEN = 6,
  parameter int EOP_SE0 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              dp_i,
  input  logic              dm_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              rx_active_o,
  output logic              rx_valid_o,
  output logic              rx_error_o
);
  rx_state_e state;
  logic lvl, se0, sync_hit, hunt, step;
  logic byte_done, stuff_err, partial;

  usb_rx_line u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .dp_i      (dp_i),
    .dm_i      (dm_i),
    .hunt_i    (hunt),
    .lvl_o     (lvl),
    .se0_o     (se0),
    .sync_hit_o(sync_hit)
  );

  usb_rx_destuff #(.BYTE_W(BYTE_W), .RUN_LEN(RUN_LEN)) u_destuff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hunt_i     (hunt),
    .start_i    (sync_hit),
    .step_i     (step),
    .lvl_i      (lvl),
    .byte_done_o(byte_done),
    .stuff_err_o(stuff_err),
    .partial_o  (partial),
    .data_o     (data_o)
  );

  usb_rx_fsm #(.EOP_SE0(EOP_SE0)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .se0_i      (se0),
    .lvl_i      (lvl),
    .sync_hit_i (sync_hit),
    .byte_done_i(byte_done),
    .stuff_err_i(stuff_err),
    .partial_i  (partial),
    .state_o    (state),
    .hunt_o     (hunt),
    .step_o     (step)
  );

  assign rx_active_o = state inside {ST_SYNC, ST_DATA, ST_GAP, ST_ERR, ST_ABORT2};
  assign rx_valid_o  = (state == ST_DATA);
  assign rx_error_o  = (state == ST_ERR);
endmodule

// File: rtl/usb_rx_path_chk.sv
module usb_rx_path_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_en_i,
  input logic [BYTE_W-1:0] data_o,
  input logic              rx_active_o,
  input logic              rx_valid_o,
  input logic              rx_error_o
);
  a_r6_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r6_valid_in_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_active_o);

  a_r6_hold_moves_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> rx_valid_o);

  a_r8_error_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_error_o |=> !rx_error_o);

  a_r8_error_in_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_error_o |-> (rx_active_o && !rx_valid_o));

  a_r2_start_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_active_o) |-> $past(bit_en_i));
endmodule

bind usb_rx_path usb_rx_path_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .data_o     (data_o),
  .rx_active_o(rx_active_o),
  .rx_valid_o (rx_valid_o),
  .rx_error_o (rx_error_o)
);

// File: tb/usb_rx_path_test.sv
module usb_rx_path_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0;
  logic dp = 1'b1;
  logic dm = 1'b0;
  logic [7:0] data;
  logic act, vld, err;

  always #10 clk = ~clk;

  usb_rx_path uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .dp_i(dp), .dm_i(dm),
    .data_o(data), .rx_active_o(act), .rx_valid_o(vld), .rx_error_o(err)
  );

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit running = 1'b0;
  logic [7:0] got[$];
  int err_pulses = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int actual, input int expect_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expect_v);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // states: 0 reset,1 hunt,2 marker,3 byte,4 gap,5 eop,6 err,7 abort-a,8 abort-b,9 exit
  int m_st;
  logic [7:0] m_hold, m_acc;
  int m_hist[$];
  logic m_prev;
  int m_ones, m_nb, m_se0;
  bit m_ab2;
  int sync_ref[8] = '{0, 1, 0, 1, 0, 1, 0, 0};

  function automatic void fill_j();
    m_hist = {};
    for (int i = 0; i < 8; i++) m_hist.push_back(1);
  endfunction

  function automatic void model_step(logic en, logic p, logic m);
    logic se0 = !p && !m;
    logic lv = p;
    int nst = m_st;
    bit hit;
    logic b;
    if (m_st != 1) fill_j();
    case (m_st)
      0: nst = 1;
      1: if (en) begin
        if (se0) fill_j();
        else begin
          m_hist.push_back(int'(lv));
          void'(m_hist.pop_front());
          hit = 1;
          for (int i = 0; i < 8; i++) if (m_hist[i] != sync_ref[i]) hit = 0;
          if (hit) begin
            nst = 2; m_prev = lv; m_ones = 1; m_nb = 0; m_se0 = 0;
          end
        end
      end
      2, 3, 4: begin
        if (m_st == 3) nst = 4;
        if (en) begin
          if (se0) begin
            if (m_se0 < 2) m_se0++;
          end else if (m_se0 >= 2 && lv) begin
            if (m_nb != 0) begin nst = 6; m_ab2 = 1; end
            else nst = 5;
          end else if (m_se0 != 0) begin
            nst = 6; m_ab2 = 0;
          end else begin
            b = (lv == m_prev);
            m_prev = lv;
            if (m_ones == 6) begin
              if (b) begin nst = 6; m_ab2 = 0; end
              else m_ones = 0;
            end else begin
              m_ones = b ? m_ones + 1 : 0;
              m_acc = {b, m_acc[7:1]};
              m_nb++;
              if (m_nb == 8) begin m_nb = 0; m_hold = m_acc; nst = 3; end
            end
          end
        end
      end
      5, 7, 9: nst = 1;
      6: nst = m_ab2 ? 8 : 7;
      8: if (en && lv && !se0) nst = 9;
      default: nst = 1;
    endcase
    m_st = nst;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_hold = 8'h00; m_acc = 8'h00; m_se0 = 0; m_nb = 0; m_ones = 0;
      m_ab2 = 0; m_prev = 1; fill_j();
    end else model_step(bit_en, dp, dm);
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      chk(act == (m_st inside {2, 3, 4, 6, 8}), cur_req, "rx_active", act, m_st inside {2, 3, 4, 6, 8});
      chk(vld == (m_st == 3), cur_req, "rx_valid", vld, m_st == 3);
      chk(err == (m_st == 6), cur_req, "rx_error", err, m_st == 6);
      chk(data == m_hold, cur_req, "data", data, m_hold);
      if (vld) got.push_back(data);
      if (err) err_pulses++;
    end
  end

  // ---------------- line driver ----------------
  logic line_lvl = 1'b1;
  int tx_ones = 0;

  task automatic strobe(input logic p, input logic m);
    @(negedge clk); bit_en = 1'b1; dp = p; dm = m;
    @(negedge clk); bit_en = 1'b0; dp = 1'($urandom); dm = 1'($urandom);
    @(negedge clk);
  endtask

  task automatic send_lvl(input logic l);
    strobe(l, ~l);
  endtask

  task automatic send_raw(input logic b);
    if (!b) line_lvl = ~line_lvl;
    send_lvl(line_lvl);
  endtask

  task automatic send_bit(input logic b);
    send_raw(b);
    tx_ones = b ? tx_ones + 1 : 0;
    if (tx_ones == 6) begin
      send_raw(1'b0);
      tx_ones = 0;
    end
  endtask

  task automatic send_sync(input int len);
    line_lvl = 1'b1;
    tx_ones = 0;
    repeat (len - 1) send_bit(1'b0);
    send_bit(1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic send_eop();
    strobe(1'b0, 1'b0);
    strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b0);
    line_lvl = 1'b1;
  endtask

  task automatic expect_bytes(input string req, input logic [7:0] exp_q[$]);
    chk(got.size() == exp_q.size(), req, "byte count", got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], req, "byte value", got[i], exp_q[i]);
    got = {};
  endtask

  task automatic finish_run();
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int e0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!act && !vld && !err, "R1", "flags in reset", {act, vld, err}, 0);
    chk(data == 8'h00, "R1", "data in reset", data, 0);
    running = 1'b1;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R12: marker pattern on the pair with no strobe
    cur_req = "R12";
    for (int i = 0; i < 8; i++) begin
      dp = sync_ref[i][0]; dm = ~sync_ref[i][0];
      @(negedge clk);
    end
    dp = 1'b1; dm = 1'b0;
    @(negedge clk);
    chk(!act, "R12", "no start without strobe", act, 0);

    // R2 / R4 / R6 / R7: plain packet
    cur_req = "R2";
    send_sync(8);
    chk(act, "R2", "active after marker", act, 1);
    cur_req = "R4";
    send_byte(8'hA5); send_byte(8'h3C);
    cur_req = "R7";
    send_eop();
    repeat (2) @(negedge clk);
    chk(!act, "R7", "active dropped after end marker", act, 0);
    expect_bytes("R6", '{8'hA5, 8'h3C});

    // R5: stuffed bits removed
    cur_req = "R5";
    send_sync(8);
    send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h7E);
    send_eop();
    expect_bytes("R5", '{8'hFF, 8'hFF, 8'h7E});

    // R3 + R11: long marker right after previous packet
    cur_req = "R3";
    send_sync(32);
    send_byte(8'h00); send_byte(8'h81);
    send_eop();
    expect_bytes("R3", '{8'h00, 8'h81});
    cur_req = "R11";
    send_sync(8);
    send_byte(8'hC3);
    send_eop();
    expect_bytes("R11", '{8'hC3});

    // R2: SE0 during hunt restarts search
    cur_req = "R2";
    line_lvl = 1'b1;
    for (int i = 0; i < 7; i++) send_lvl(sync_ref[i][0]);
    strobe(1'b0, 1'b0);
    send_lvl(1'b0);
    repeat (2) @(negedge clk);
    chk(!act, "R2", "SE0 restarts hunt", act, 0);
    send_lvl(1'b1); send_lvl(1'b1);

    // R8: unstuffed run of ones
    cur_req = "R8";
    e0 = err_pulses;
    send_sync(8);
    send_byte(8'h55);
    repeat (7) send_raw(1'b1);
    chk(err_pulses == e0 + 1, "R8", "one error pulse", err_pulses - e0, 1);
    chk(!act, "R8", "dropped after stuff error", act, 0);
    expect_bytes("R8", '{8'h55});
    send_lvl(1'b1);

    // R9: stray single SE0
    cur_req = "R9";
    e0 = err_pulses;
    send_sync(8);
    send_byte(8'h12);
    strobe(1'b0, 1'b0);
    send_lvl(1'b0);
    chk(err_pulses == e0 + 1, "R9", "one error pulse", err_pulses - e0, 1);
    chk(!act, "R9", "dropped after bad SE0", act, 0);
    expect_bytes("R9", '{8'h12});
    send_lvl(1'b1);

    // R10: end marker inside a byte
    cur_req = "R10";
    e0 = err_pulses;
    send_sync(8);
    send_byte(8'h5A);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_eop();
    chk(err_pulses == e0 + 1, "R10", "one error pulse", err_pulses - e0, 1);
    send_lvl(1'b0); send_lvl(1'b0);
    chk(act, "R10", "active held until idle", act, 1);
    send_lvl(1'b1);
    chk(!act, "R10", "active dropped after idle J", act, 0);
    expect_bytes("R10", '{8'h5A});

    // R11: clean packet after abort
    cur_req = "R11";
    send_sync(8);
    send_byte(8'h96);
    send_eop();
    expect_bytes("R11", '{8'h96});

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule